// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block controls a port of sixteen general-purpose pins through a small word-addressed register interface. Software chooses a mode for each pin: input, general output, or alternate function. It also sets each pin's output type and pull request, writes the output levels, reads the sampled input levels, and picks which of sixteen peripheral sources drives a pin in alternate-function mode. Each pin presents an output value, an output enable, an open-drain flag and pull-up/pull-down requests to the pad ring. Each pin also presents its 4-bit source selection to an external multiplexer.

Output bits can be changed atomically through a write-only set/clear register, so no read-modify-write is needed. Pin levels reach the input register through a two-stage synchronizer. The bus read path is combinational. A write takes effect on the clock edge where `bus_we` is high.

Register word addresses on `bus_addr`:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | output type |
| 2 | pull |
| 3 | input data (read-only) |
| 4 | output data |
| 5 | set/clear (write-only) |
| 6 | alternate-function select, pins 0–7 |
| 7 | alternate-function select, pins 8–15 |

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every register reads 0. `pad_oe`, `pad_od`, `pad_pu`, `pad_pd` and `af_sel` are all 0, so every pin is a floating input.
- R2: When a pin's mode field is 01 (bits 2p+1:2p of the mode register) and its output-type bit is 0, `pad_out[p]` equals output-data bit p and `pad_oe[p]` is 1.
- R3: When the output-type bit p is 1 (open-drain) in mode 01 or 10, `pad_od[p]` is 1 and `pad_out[p]` is 0. `pad_oe[p]` is 1 only when the pin would drive a 0; a driven 1 turns the driver off.
- R4: In mode 00 (input), `pad_oe[p]` and `pad_od[p]` are 0 whatever the output-type bit holds.
- R5: Pull field p (bits 2p+1:2p of the pull register) gives 01 as pull-up (`pad_pu[p]`=1), 10 as pull-down (`pad_pd[p]`=1), and 00 or 11 as neither. This applies in every mode.
- R6: The output-data register (address 4) holds bits 15:0 of the last write and reads back zero-extended. It changes only on writes to address 4 or 5.
- R7: A write to address 5 sets output bit p when wdata bit p is 1 and clears it when wdata bit 16+p is 1. When both are 1, the set wins. Bits with both halves 0 keep their value.
- R8: Address 5 always reads 0.
- R9: The input-data register (address 3) shows a change on `pin_in` after two rising clock edges. It still shows the old value after one edge.
- R10: Pin p's 4-bit source select is bits 4(p mod 8)+3:4(p mod 8) of address 6 for pins 0–7 and of address 7 for pins 8–15. `af_sel[4p+3:4p]` presents it, and both registers read back fully.
- R11: In mode 10, pin p's output value and enable come from `af_dout[16p+s]` and `af_oe[16p+s]`, where s is its source select. Open-drain follows R3.
- R12: Mode 11 behaves as input: `pad_out`, `pad_oe` and `pad_od` are 0 for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| af_dout | input | 256 | Peripheral output values, 16 sources per pin |
| af_oe | input | 256 | Peripheral output enables, 16 sources per pin |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad driver enable |
| pad_od | output | 16 | Pad open-drain indication |
| pad_pu | output | 16 | Pull-up request |
| pad_pd | output | 16 | Pull-down request |
| af_sel | output | 64 | Per-pin 4-bit source select for the external mux |

## Verification
A corrupted configuration register appears at the pad outputs in the same cycle, because those outputs are decoded combinationally from register state. It also appears on a readback of that address. A wrong output-data update after a set/clear write shows on `pad_out` one edge after the write, so each atomic write is checked right after its edge, including the case where set and clear hit the same pin. A synchronizer with the wrong depth shows only in timing: the input register is sampled after exactly one edge and after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_GPO = 2'b01,
    PM_ALT = 2'b10,
    PM_RSV = 2'b11
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_OTYPE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PULL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IDATA  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ODATA  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SETCLR = 3'd5;
  localparam logic [ADDR_W-1:0] A_AFLO   = 3'd6;
  localparam logic [ADDR_W-1:0] A_AFHI   = 3'd7;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;
  logic [1:0]   age_q, age_d;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
    age_d  = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      age_q  <= age_d;
    end
  end

  assign q = sync_q;

  // R9: two edges of latency once the pipeline is filled since reset
  assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   idata,
  output logic [2*NPIN-1:0] mode_q,
  output logic [NPIN-1:0]   otype_q,
  output logic [2*NPIN-1:0] pull_q,
  output logic [NPIN-1:0]   odata_q,
  output logic [2*DW-1:0]   afsel_q
);
  logic              en_mode, en_otype, en_pull, en_odata, en_aflo, en_afhi;
  logic [NPIN-1:0]   set_bits, clr_bits, odata_d;

  always_comb begin
    en_mode  = bus_we && (bus_addr == A_MODE);
    en_otype = bus_we && (bus_addr == A_OTYPE);
    en_pull  = bus_we && (bus_addr == A_PULL);
    en_aflo  = bus_we && (bus_addr == A_AFLO);
    en_afhi  = bus_we && (bus_addr == A_AFHI);
    en_odata = bus_we && ((bus_addr == A_ODATA) || (bus_addr == A_SETCLR));
    set_bits = bus_wdata[NPIN-1:0];
    clr_bits = bus_wdata[2*NPIN-1:NPIN];
    if (bus_addr == A_SETCLR) odata_d = (odata_q & ~clr_bits) | set_bits;
    else                      odata_d = set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      pull_q  <= '0;
      odata_q <= '0;
      afsel_q <= '0;
    end else begin
      if (en_mode)  mode_q           <= bus_wdata[2*NPIN-1:0];
      if (en_otype) otype_q          <= bus_wdata[NPIN-1:0];
      if (en_pull)  pull_q           <= bus_wdata[2*NPIN-1:0];
      if (en_odata) odata_q          <= odata_d;
      if (en_aflo)  afsel_q[DW-1:0]  <= bus_wdata;
      if (en_afhi)  afsel_q[2*DW-1:DW] <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = DW'(mode_q);
      A_OTYPE: bus_rdata = DW'(otype_q);
      A_PULL:  bus_rdata = DW'(pull_q);
      A_IDATA: bus_rdata = DW'(idata);
      A_ODATA: bus_rdata = DW'(odata_q);
      A_AFLO:  bus_rdata = afsel_q[DW-1:0];
      A_AFHI:  bus_rdata = afsel_q[2*DW-1:DW];
      default: bus_rdata = '0;
    endcase
  end

  // R7: every pin named in the set half ends up high
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SETCLR) |=>
      ((odata_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  // R7: a clear without a matching set leaves the pin low
  assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SETCLR) |=>
      ((odata_q & $past(bus_wdata[2*NPIN-1:NPIN]) & ~$past(bus_wdata[NPIN-1:0])) == '0));

  // R6: output data holds unless addressed
  assert_odata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_ODATA || bus_addr == A_SETCLR)) |=> $stable(odata_q));
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned AF_W = 4,
  localparam int unsigned AF_N = 1 << AF_W
) (
  input  pin_mode_e       mode,
  input  logic            otype,
  input  logic [1:0]      pull,
  input  logic            odata,
  input  logic [AF_W-1:0] src_sel,
  input  logic [AF_N-1:0] src_dout,
  input  logic [AF_N-1:0] src_oe,
  output logic            out,
  output logic            oe,
  output logic            od,
  output logic            pu,
  output logic            pd
);
  logic drv_val, drv_en, driving;

  always_comb begin
    drv_val = 1'b0;
    drv_en  = 1'b0;
    driving = 1'b0;
    unique case (mode)
      PM_GPO: begin drv_val = odata;            drv_en = 1'b1;             driving = 1'b1; end
      PM_ALT: begin drv_val = src_dout[src_sel]; drv_en = src_oe[src_sel]; driving = 1'b1; end
      default: ;
    endcase
    if (driving && otype) begin
      out = 1'b0;
      oe  = drv_en & ~drv_val;
      od  = 1'b1;
    end else begin
      out = drv_val;
      oe  = drv_en;
      od  = 1'b0;
    end
    pu = (pull == 2'b01);
    pd = (pull == 2'b10);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned AF_W = 4,
  parameter int unsigned DW   = 32,
  localparam int unsigned AF_N = 1 << AF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_we,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NPIN-1:0]      pin_in,
  input  logic [NPIN*AF_N-1:0] af_dout,
  input  logic [NPIN*AF_N-1:0] af_oe,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_od,
  output logic [NPIN-1:0]      pad_pu,
  output logic [NPIN-1:0]      pad_pd,
  output logic [NPIN*AF_W-1:0] af_sel
);
  logic              rst_sn;
  logic [NPIN-1:0]   idata;
  logic [2*NPIN-1:0] mode_q, pull_q;
  logic [NPIN-1:0]   otype_q, odata_q;
  logic [2*DW-1:0]   afsel_q;

  gpio_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(pin_in), .q(idata)
  );

  gpio_cfg_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .idata(idata),
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q),
    .odata_q(odata_q), .afsel_q(afsel_q)
  );

  assign af_sel = afsel_q[NPIN*AF_W-1:0];

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    gpio_pin_ctrl #(.AF_W(AF_W)) u_pin (
      .mode(pin_mode_e'(mode_q[2*p +: 2])),
      .otype(otype_q[p]),
      .pull(pull_q[2*p +: 2]),
      .odata(odata_q[p]),
      .src_sel(afsel_q[AF_W*p +: AF_W]),
      .src_dout(af_dout[AF_N*p +: AF_N]),
      .src_oe(af_oe[AF_N*p +: AF_N]),
      .out(pad_out[p]), .oe(pad_oe[p]), .od(pad_od[p]),
      .pu(pad_pu[p]), .pd(pad_pd[p])
    );

    // R4 / R12: a non-driving mode never enables the pad
    assert_quiet_input_R4: assert property (@(posedge clk) disable iff (!rst_sn)
      (mode_q[2*p +: 2] == PM_IN || mode_q[2*p +: 2] == PM_RSV) |-> (!pad_oe[p] && !pad_od[p]));

    // R3: an open-drain pad never drives a high level
    assert_od_no_high_R3: assert property (@(posedge clk) disable iff (!rst_sn)
      pad_od[p] |-> !(pad_oe[p] && pad_out[p]));
  end
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  import gpio_port_pkg::*;

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       tag;
  } item_t;

  localparam int S_RD = 0, S_OUT = 1, S_OE = 2, S_OD = 3, S_PU = 4, S_PD = 5,
                 S_AFL = 6, S_AFH = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic         bus_we;
  logic [31:0]  bus_rdata;
  logic [15:0]  pin_in;
  logic [255:0] af_dout, af_oe;
  logic [15:0]  pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [63:0]  af_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .af_dout(af_dout), .af_oe(af_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd), .af_sel(af_sel)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      case (it.sel)
        S_RD:    got = bus_rdata;
        S_OUT:   got = {16'h0, pad_out};
        S_OE:    got = {16'h0, pad_oe};
        S_OD:    got = {16'h0, pad_od};
        S_PU:    got = {16'h0, pad_pu};
        S_PD:    got = {16'h0, pad_pd};
        S_AFL:   got = af_sel[31:0];
        default: got = af_sel[63:32];
      endcase
      n_chk++;
      if (got !== it.val) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.val);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(); bus_we = 1'b0;
  endtask

  task automatic expect_v(input int sel, input logic [31:0] v, input string tag);
    item_t it;
    it.sel = sel; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    step(); bus_addr = a; expect_v(S_RD, v, tag);
  endtask

  function automatic int src_of(input int p);
    return (p < 8) ? p : 23 - p;
  endfunction

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pin_in = '0;
    af_dout = '0; af_oe = '1;
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 16; k++)
        af_dout[p*16+k] = (k == src_of(p)) ? (p % 2 == 0) : (p % 2 != 0);
    af_oe[3*16 + src_of(3)] = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 register reset");
    expect_v(S_OE, 0, "R1 oe"); expect_v(S_OD, 0, "R1 od");
    expect_v(S_PU, 0, "R1 pu"); expect_v(S_PD, 0, "R1 pd");
    expect_v(S_AFL, 0, "R1 af lo"); expect_v(S_AFH, 0, "R1 af hi");

    // R6: output data write, upper half dropped
    wr(A_ODATA, 32'hFFFF_A5C3);
    rd(A_ODATA, 32'h0000_A5C3, "R6 odata readback");

    // R2: push-pull output
    wr(A_MODE, 32'h5555_5555);
    expect_v(S_OUT, 32'hA5C3, "R2 out"); expect_v(S_OE, 32'hFFFF, "R2 oe");
    expect_v(S_OD, 0, "R2 od");
    rd(A_MODE, 32'h5555_5555, "R2 mode readback");

    // R3: open drain on pins 0-7
    wr(A_OTYPE, 32'hFFFF_00FF);
    expect_v(S_OUT, 32'hA500, "R3 out"); expect_v(S_OE, 32'hFF3C, "R3 oe");
    expect_v(S_OD, 32'h00FF, "R3 od");
    rd(A_OTYPE, 32'h0000_00FF, "R3 otype readback");

    // R7: set/clear, pin 0 both -> set wins
    wr(A_SETCLR, {16'h00F1, 16'h000F});
    expect_v(S_OUT, 32'hA500, "R7 out after setclr (od low byte)");
    rd(A_ODATA, 32'h0000_A50F, "R7 set wins / clear");
    // R8: reads zero
    rd(A_SETCLR, 32'h0, "R8 setclr reads zero");
    wr(A_SETCLR, {16'hA500, 16'h0000});
    rd(A_ODATA, 32'h0000_000F, "R7 clear only");
    wr(A_SETCLR, 32'h0);
    rd(A_ODATA, 32'h0000_000F, "R7 zero write no change");
    wr(A_OTYPE, 32'h0);
    expect_v(S_OUT, 32'h000F, "R7 pads follow odata");

    // R4: input mode ignores output type
    wr(A_OTYPE, 32'h0000_FFFF);
    wr(A_MODE, 32'h0);
    expect_v(S_OE, 0, "R4 oe"); expect_v(S_OD, 0, "R4 od");

    // R12: reserved mode behaves as input
    wr(A_MODE, 32'hFFFF_FFFF);
    expect_v(S_OUT, 0, "R12 out"); expect_v(S_OE, 0, "R12 oe");
    expect_v(S_OD, 0, "R12 od");

    // R5: pulls
    wr(A_PULL, 32'h8000_0039);
    expect_v(S_PU, 32'h0001, "R5 pu"); expect_v(S_PD, 32'h8002, "R5 pd");
    rd(A_PULL, 32'h8000_0039, "R5 pull readback");

    // R9: input synchronizer latency
    step(); pin_in = 16'h1234; bus_addr = A_IDATA;
    expect_v(S_RD, 32'h0, "R9 idata after one edge");
    step(); expect_v(S_RD, 32'h1234, "R9 idata after two edges");

    // R10: alternate-function select fields
    wr(A_AFLO, 32'h7654_3210);
    wr(A_AFHI, 32'h89AB_CDEF);
    expect_v(S_AFL, 32'h7654_3210, "R10 af_sel lo");
    expect_v(S_AFH, 32'h89AB_CDEF, "R10 af_sel hi");
    rd(A_AFHI, 32'h89AB_CDEF, "R10 af hi readback");

    // R11: alternate-function drive
    wr(A_OTYPE, 32'h0);
    wr(A_MODE, 32'hAAAA_AAAA);
    expect_v(S_OUT, 32'h5555, "R11 out"); expect_v(S_OE, 32'hFFF7, "R11 oe");
    wr(A_OTYPE, 32'h000F);
    expect_v(S_OUT, 32'h5550, "R11 od out"); expect_v(S_OE, 32'hFFF2, "R11 od oe");
    expect_v(S_OD, 32'h000F, "R11 od flag");

    step(); step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule